// File: doc/BRIEF.md
# Character Display Controller Model

This block is a synthesizable stand-in for a four-line, sixteen-column character display controller as seen by a byte-wide processor bus. Software talks to it through two neighbouring bus addresses: one accepts command bytes and reports the write cursor, and the other accepts character bytes. Characters land in a 128-byte display store at a 7-bit cursor. The cursor advances by one after every character and wraps from 0x7F to 0x00.

Three command forms are decoded. A byte with its top bit set moves the cursor. A clear command blanks the whole store and homes the cursor. A home command returns the cursor to zero and leaves the text in place. Every other command byte is accepted and does nothing. A separate read-only view port takes a line number and a column and returns the stored character combinationally. A testbench or a debug path can use it to inspect what the display would show. The view port never moves the cursor.

Top module: `char_lcd_model`

## Requirements
- R1: After reset every one of the 128 store locations reads 0x20, a status read returns 0x00 and a data-port read returns 0x00.
- R2: The command/status port decodes at bus address 0xF200 and the data port at 0xF201. A write to any other address changes nothing, and a read of any other address returns 0x00.
- R3: Writing a command byte with bit 7 = 1 to 0xF200 loads the cursor with bits 6:0 of that byte.
- R4: Writing command 0x01 sets all 128 locations to 0x20 and sets the cursor to 0.
- R5: Writing command 0x02 sets the cursor to 0 and leaves the stored characters unchanged.
- R6: A write to 0xF201 stores the byte at the cursor location, then advances the cursor by one modulo 128 (0x7F is followed by 0x00).
- R7: A read strobe at 0xF200 returns, in the same cycle, the cursor in bits 6:0 with bit 7 (busy) always 0.
- R8: A read strobe at 0xF201 returns, in the same cycle, the last byte written to the data port, not the store contents. Commands do not change it.
- R9: A command byte with bit 7 = 0 other than 0x01 and 0x02 has no effect on the cursor or the store.
- R10: The view port maps line 0, 1, 2, 3 to store offsets 0x00, 0x40, 0x10, 0x50 plus the column (0..15), modulo 128, and returns that byte combinationally.
- R11: Reads through either bus port or the view port never change the cursor or the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| view_line | input | 2 | Display line to inspect |
| view_col | input | 4 | Column within that line |
| view_char | output | 8 | Stored character at that line and column |

## Verification
On every cycle the assertions check how the cursor moves after set-address, clear, home, unknown commands and character writes. They also check that the data latch captures each character, that a clear empties the store, and that a write marks its location as written. Only the bench's scenarios can show where characters actually appear on the four lines, that home keeps the text, that the data port returns the latch instead of the store, and that stray addresses and view-port scans leave everything untouched.

// File: rtl/lcdm_pkg.sv
package lcdm_pkg;

  typedef enum logic [1:0] {
    CMD_IGNORE  = 2'd0,
    CMD_SETADDR = 2'd1,
    CMD_CLEAR   = 2'd2,
    CMD_HOME    = 2'd3
  } lcdm_cmd_e;

  // Classify a command byte; bit 7 selects set-address, then exact codes.
  function automatic lcdm_cmd_e classify_cmd(input logic [7:0] v);
    if (v[7])          return CMD_SETADDR;
    else if (v == 8'h01) return CMD_CLEAR;
    else if (v == 8'h02) return CMD_HOME;
    else               return CMD_IGNORE;
  endfunction

  // Store offset of the first column of a visible line:
  // line bit 0 adds 0x40, line bit 1 adds 0x10.
  function automatic logic [6:0] line_origin(input logic [1:0] line);
    logic [6:0] base;
    base = 7'h00;
    if (line[0]) base = base + 7'h40;
    if (line[1]) base = base + 7'h10;
    return base;
  endfunction

endpackage

// File: rtl/lcdm_bus_ctrl.sv
module lcdm_bus_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 7,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 16'hF200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_waddr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_clear
);
  import lcdm_pkg::*;

  localparam logic [ADDR_W-1:0] DAT_ADDR = CMD_ADDR + ADDR_W'(1);

  logic              cmd_sel, dat_sel, cmd_wr, dat_wr;
  lcdm_cmd_e         kind;
  logic [RAM_AW-1:0] cursor;
  logic [DATA_W-1:0] data_latch;

  assign cmd_sel = (bus_addr == CMD_ADDR);
  assign dat_sel = (bus_addr == DAT_ADDR);
  assign cmd_wr  = bus_wr && cmd_sel;
  assign dat_wr  = bus_wr && dat_sel;
  assign kind    = classify_cmd(bus_wdata[7:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cursor     <= '0;
      data_latch <= '0;
    end else if (dat_wr) begin
      data_latch <= bus_wdata;
      cursor     <= cursor + RAM_AW'(1);
    end else if (cmd_wr) begin
      unique case (kind)
        CMD_SETADDR: cursor <= bus_wdata[RAM_AW-1:0];
        CMD_CLEAR:   cursor <= '0;
        CMD_HOME:    cursor <= '0;
        default:     cursor <= cursor;
      endcase
    end
  end

  assign ram_we    = dat_wr;
  assign ram_waddr = cursor;
  assign ram_wdata = bus_wdata;
  assign ram_clear = cmd_wr && (kind == CMD_CLEAR);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && cmd_sel)      bus_rdata = DATA_W'(cursor);
    else if (bus_rd && dat_sel) bus_rdata = data_latch;
  end

  AST_CURSOR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    dat_wr |=> cursor == $past(cursor) + RAM_AW'(1)); // R6
  AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    dat_wr |=> data_latch == $past(bus_wdata)); // R8
  AST_SETADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata[7]) |=> cursor == $past(bus_wdata[RAM_AW-1:0])); // R3
  AST_HOME_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && (bus_wdata == DATA_W'(1) || bus_wdata == DATA_W'(2))) |=> cursor == '0); // R5
  AST_UNKNOWN_CMD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !bus_wdata[7] && bus_wdata != DATA_W'(1) && bus_wdata != DATA_W'(2))
      |=> $stable(cursor)); // R9
  AST_LATCH_CMD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!dat_wr) |=> $stable(data_latch)); // R8
  AST_STATUS_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && cmd_sel) |-> !bus_rdata[7]); // R7

endmodule

// File: rtl/lcdm_char_ram.sv
module lcdm_char_ram #(
  parameter int DATA_W = 8,
  parameter int RAM_AW = 7,
  parameter logic [DATA_W-1:0] BLANK = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RAM_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clear,
  input  logic [RAM_AW-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << RAM_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  written;

  // Plain write port without reset so the array maps onto RAM resources.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // One flag per location: a cleared or never-written location reads blank.
  always_ff @(posedge clk) begin
    if (rst || clear) written <= '0;
    else if (we)      written[waddr] <= 1'b1;
  end

  assign rdata = written[raddr] ? mem[raddr] : BLANK;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clear |=> written == '0); // R4
  AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (rst)
    we |=> written[$past(waddr)]); // R6
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (we && raddr == waddr) |=> (raddr != $past(raddr)) || rdata == $past(wdata)); // R6

endmodule

// File: rtl/lcdm_line_map.sv
module lcdm_line_map #(
  parameter int LINE_W = 2,
  parameter int COL_W  = 4,
  parameter int RAM_AW = 7
) (
  input  logic [LINE_W-1:0] line,
  input  logic [COL_W-1:0]  col,
  output logic [RAM_AW-1:0] addr
);
  import lcdm_pkg::*;

  logic [6:0] origin;

  assign origin = line_origin(line[1:0]);
  assign addr   = RAM_AW'(origin) + RAM_AW'(col);

endmodule

// File: rtl/char_lcd_model.sv
module char_lcd_model #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 7,
  parameter int LINE_W = 2,
  parameter int COL_W  = 4,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 16'hF200,
  parameter logic [DATA_W-1:0] BLANK    = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [LINE_W-1:0] view_line,
  input  logic [COL_W-1:0]  view_col,
  output logic [DATA_W-1:0] view_char
);
  logic              ram_we, ram_clear;
  logic [RAM_AW-1:0] ram_waddr, view_addr;
  logic [DATA_W-1:0] ram_wdata;

  lcdm_bus_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_AW(RAM_AW), .CMD_ADDR(CMD_ADDR)
  ) ctrl_i (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_clear(ram_clear)
  );

  lcdm_line_map #(
    .LINE_W(LINE_W), .COL_W(COL_W), .RAM_AW(RAM_AW)
  ) map_i (
    .line(view_line), .col(view_col), .addr(view_addr)
  );

  lcdm_char_ram #(
    .DATA_W(DATA_W), .RAM_AW(RAM_AW), .BLANK(BLANK)
  ) ram_i (
    .clk(clk), .rst(rst),
    .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .clear(ram_clear), .raddr(view_addr), .rdata(view_char)
  );

endmodule

// File: tb/char_lcd_model_tb.sv
module char_lcd_model_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [1:0]  view_line;
  logic [3:0]  view_col;
  logic [7:0]  view_char;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  char_lcd_model dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .view_line(view_line), .view_col(view_col), .view_char(view_char)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_VW = 2'd2;
  localparam int NV = 22;
  // {req, op, addr, data (view: {line,col}), expected}
  localparam logic [37:0] VEC [NV] = '{
    {4'd3,  OP_WR, 16'hF200, 8'h80, 8'h00}, // R3 cursor to 0x00
    {4'd6,  OP_WR, 16'hF201, 8'h41, 8'h00}, // R6 'A' at 0x00
    {4'd6,  OP_WR, 16'hF201, 8'h42, 8'h00}, // R6 'B' at 0x01
    {4'd7,  OP_RD, 16'hF200, 8'h00, 8'h02}, // R7 cursor now 2
    {4'd8,  OP_RD, 16'hF201, 8'h00, 8'h42}, // R8 last data byte
    {4'd6,  OP_VW, 16'h0000, 8'h00, 8'h41}, // R6 line 0 col 0
    {4'd3,  OP_WR, 16'hF200, 8'hC0, 8'h00}, // R3 cursor to 0x40
    {4'd6,  OP_WR, 16'hF201, 8'h31, 8'h00}, // R6
    {4'd10, OP_VW, 16'h0000, 8'h10, 8'h31}, // R10 line 1 starts at 0x40
    {4'd3,  OP_WR, 16'hF200, 8'h9F, 8'h00}, // R3 cursor to 0x1F
    {4'd6,  OP_WR, 16'hF201, 8'h32, 8'h00}, // R6
    {4'd10, OP_VW, 16'h0000, 8'h2F, 8'h32}, // R10 line 2 col 15 is 0x1F
    {4'd9,  OP_WR, 16'hF200, 8'h05, 8'h00}, // R9 unknown command
    {4'd9,  OP_RD, 16'hF200, 8'h00, 8'h20}, // R9 cursor still 0x20
    {4'd3,  OP_WR, 16'hF200, 8'hD3, 8'h00}, // R3 cursor to 0x53
    {4'd6,  OP_WR, 16'hF201, 8'h33, 8'h00}, // R6
    {4'd10, OP_VW, 16'h0000, 8'h33, 8'h33}, // R10 line 3 col 3 is 0x53
    {4'd2,  OP_WR, 16'hF100, 8'h55, 8'h00}, // R2 stray write
    {4'd2,  OP_RD, 16'hF200, 8'h00, 8'h54}, // R2 cursor unchanged
    {4'd2,  OP_RD, 16'hF100, 8'h00, 8'h00}, // R2 stray read is zero
    {4'd5,  OP_WR, 16'hF200, 8'h02, 8'h00}, // R5 home
    {4'd5,  OP_VW, 16'h0000, 8'h01, 8'h42}  // R5 text kept at 0x01
  };

  task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic view(input logic [1:0] l, input logic [3:0] c, output logic [7:0] d);
    @(negedge clk);
    view_line = l; view_col = c;
    #1 d = view_char;
  endtask

  task automatic all_blank(input int req, input string what);
    logic [7:0] d;
    int bad = 0;
    for (int l = 0; l < 4; l++)
      for (int c = 0; c < 16; c++) begin
        view(2'(l), 4'(c), d);
        if (d !== 8'h20) bad++;
      end
    chk(req, 8'(bad), 8'h00, what);
  endtask

  initial begin
    logic [7:0] d;
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    view_line = '0; view_col = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    all_blank(1, "non-blank positions after reset");
    bus_read(16'hF200, d); chk(1, d, 8'h00, "status after reset");
    bus_read(16'hF201, d); chk(1, d, 8'h00, "data latch after reset");

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      case (v[33:32])
        OP_WR: bus_write(v[31:16], v[15:8]);
        OP_RD: begin bus_read(v[31:16], d); chk(int'(v[37:34]), d, v[7:0], "vector read"); end
        default: begin view(v[13:12], v[11:8], d); chk(int'(v[37:34]), d, v[7:0], "vector view"); end
      endcase
    end

    // R6 wrap from 0x7F to 0x00
    bus_write(16'hF200, 8'hFF);
    bus_write(16'hF201, 8'h5A);
    bus_read(16'hF200, d); chk(6, d, 8'h00, "cursor wrap");
    bus_write(16'hF201, 8'h61);
    view(2'd0, 4'd0, d); chk(6, d, 8'h61, "write after wrap lands at 0");

    // R11 reads and view scans leave cursor alone
    bus_write(16'hF200, 8'h85);
    for (int k = 0; k < 16; k++) view(2'(k), 4'(k), d);
    bus_read(16'hF201, d);
    bus_read(16'hF200, d); chk(11, d, 8'h05, "cursor after reads");
    bus_read(16'hF200, d); chk(11, d, 8'h05, "cursor after repeated status read");

    // R4 clear
    bus_write(16'hF200, 8'h01);
    bus_read(16'hF200, d); chk(4, d, 8'h00, "cursor after clear");
    all_blank(4, "non-blank positions after clear");
    bus_read(16'hF201, d); chk(8, d, 8'h61, "latch survives clear");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule